// File: doc/BRIEF.md
# Host Bridge Configuration Register Space

This block holds the 128-byte type-0 configuration space of a host-to-PCI bridge. A byte-wide port carries an offset, write data and a write strobe. Reads are combinational, so the addressed byte appears on the read bus in the same cycle. Writes take effect at the next rising clock edge.

The block has a per-offset write policy:

- Identification bytes are wired constants.
- A fixed set of control bytes accepts plain writes.
- The high status byte only clears bits when a 1 is written to them.
- The cache control byte has its size field forced.
- Writes to every other offset are dropped.

Selected fields are exported as control signals for the cache, shadow-memory and SMRAM logic elsewhere in the chip. Reset is synchronous and active high.

Top module: `hb_cfg_space`

## Requirements
- R1: Offsets 0x00..0x03 read 0x60, 0x10, 0x81, 0x88. Offset 0x08 reads 0x04. Offsets 0x09..0x0B read 0x00, 0x00, 0x06. Writes never change these values.
- R2: A write to offset 0x04, 0x05, 0x0C, 0x0D or 0x51..0x61 stores the data byte. The byte reads back from the cycle after the write edge.
- R3: Writes to any offset not named in R2, R4 or R5 have no effect. Such an offset, other than the identification bytes of R1, reads 0x00.
- R4: A write to offset 0x07 clears each stored bit whose data bit is 1 under mask 0xF9. All other bits of the byte keep their value. Offset 0x07 resets to 0x02.
- R5: A write to offset 0x50 stores (data & 0xF8) | 0x04, so bits 2..0 read 100b after any write.
- R6: `l2_en` is bit 7 of offset 0x50. `l2_wback` is bit 6 (1 = write-back). `l2_dual_bank` is bit 3.
- R7: After reset the following offsets hold non-zero values: 0x51=0x01, 0x52=0x01, 0x5A=0x04, 0x5C=0xC0, 0x5D=0x20, 0x5F=0xFF, 0x60=0x20. Every other writable byte, including 0x50, holds 0x00.
- R8: When a read and a write target the same offset in one cycle, the read returns the old value.
- R9: `shadow_lo`, `shadow_hi` and `smram_ctl` equal the stored bytes at 0x54, 0x55 and 0x60.
- R10: Offsets 0x62..0x7F always read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_addr | input | 7 | Byte offset in configuration space |
| cfg_wdata | input | 8 | Write data |
| cfg_we | input | 1 | Write strobe |
| cfg_rdata | output | 8 | Read data for cfg_addr, combinational |
| l2_en | output | 1 | External L2 cache enable |
| l2_wback | output | 1 | L2 write policy, 1 = write-back |
| l2_dual_bank | output | 1 | L2 uses two banks |
| shadow_lo | output | 8 | Shadow control byte at 0x54 |
| shadow_hi | output | 8 | Shadow control byte at 0x55 |
| smram_ctl | output | 8 | SMRAM control byte at 0x60 |

## Verification
Read data is due in the same cycle the offset is presented, so the bench checks it one nanosecond after driving the address, well away from any edge. A write becomes visible only after the next rising edge. The bench therefore samples the old value while the strobe is still high, then compares the read bus and the exported fields at the falling edge that follows. Exported fields go through no extra register, so they are checked on the same schedule as a read-back.

// File: rtl/hb_cfg_space.sv
module hb_cfg_space (
  input  logic       clk,
  input  logic       rst,
  input  logic [6:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  input  logic       cfg_we,
  output logic [7:0] cfg_rdata,
  output logic       l2_en,
  output logic       l2_wback,
  output logic       l2_dual_bank,
  output logic [7:0] shadow_lo,
  output logic [7:0] shadow_hi,
  output logic [7:0] smram_ctl
);

  localparam logic [6:0] BANK_BASE = 7'h50;
  localparam int         BANK_N    = 18;
  localparam logic [7:0] STS_MASK  = 8'hF9;

  function automatic logic [7:0] bank_init(int i);
    case (i)
      1, 2:    bank_init = 8'h01;
      10:      bank_init = 8'h04;
      12:      bank_init = 8'hC0;
      13, 16:  bank_init = 8'h20;
      15:      bank_init = 8'hFF;
      default: bank_init = 8'h00;
    endcase
  endfunction

  logic [7:0] cmd_lo, cmd_hi, sts_hi, line_sz, lat_tmr;
  logic [7:0] bank [BANK_N];

  logic       in_bank;
  logic [6:0] bank_idx;

  assign in_bank  = (cfg_addr >= BANK_BASE) && (cfg_addr < BANK_BASE + 7'(BANK_N));
  assign bank_idx = cfg_addr - BANK_BASE;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_lo  <= 8'h00;
      cmd_hi  <= 8'h00;
      sts_hi  <= 8'h02;
      line_sz <= 8'h00;
      lat_tmr <= 8'h00;
    end else if (cfg_we) begin
      case (cfg_addr)
        7'h04: cmd_lo  <= cfg_wdata;
        7'h05: cmd_hi  <= cfg_wdata;
        7'h07: sts_hi  <= sts_hi & ~(cfg_wdata & STS_MASK);
        7'h0C: line_sz <= cfg_wdata;
        7'h0D: lat_tmr <= cfg_wdata;
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < BANK_N; i++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)
        bank[i] <= bank_init(i);
      else if (cfg_we && in_bank && bank_idx == 7'(i))
        bank[i] <= (i == 0) ? ((cfg_wdata & 8'hF8) | 8'h04) : cfg_wdata;
    end
  end

  always_comb begin
    case (cfg_addr)
      7'h00: cfg_rdata = 8'h60;
      7'h01: cfg_rdata = 8'h10;
      7'h02: cfg_rdata = 8'h81;
      7'h03: cfg_rdata = 8'h88;
      7'h04: cfg_rdata = cmd_lo;
      7'h05: cfg_rdata = cmd_hi;
      7'h07: cfg_rdata = sts_hi;
      7'h08: cfg_rdata = 8'h04;
      7'h0B: cfg_rdata = 8'h06;
      7'h0C: cfg_rdata = line_sz;
      7'h0D: cfg_rdata = lat_tmr;
      default: cfg_rdata = in_bank ? bank[bank_idx[4:0]] : 8'h00;
    endcase
  end

  assign l2_en        = bank[0][7];
  assign l2_wback     = bank[0][6];
  assign l2_dual_bank = bank[0][3];
  assign shadow_lo    = bank[4];
  assign shadow_hi    = bank[5];
  assign smram_ctl    = bank[16];

endmodule

// File: rtl/hb_cfg_space_chk.sv
module hb_cfg_space_chk (
  input logic       clk,
  input logic       rst,
  input logic [6:0] cfg_addr,
  input logic [7:0] cfg_wdata,
  input logic       cfg_we,
  input logic [7:0] cfg_rdata,
  input logic       l2_en,
  input logic [7:0] shadow_lo,
  input logic [7:0] smram_ctl
);

  AST_VENDOR_LO: assert property (@(posedge clk) disable iff (rst)
    cfg_addr == 7'h00 |-> cfg_rdata == 8'h60); // R1

  AST_CLASS_HI: assert property (@(posedge clk) disable iff (rst)
    cfg_addr == 7'h0B |-> cfg_rdata == 8'h06); // R1

  AST_SHADOW_WRITE: assert property (@(posedge clk) disable iff (rst)
    cfg_we && cfg_addr == 7'h54 |=> shadow_lo == $past(cfg_wdata)); // R2

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(cfg_we && cfg_addr == 7'h54) |=> $stable(shadow_lo)); // R2

  AST_STATUS_NO_SET: assert property (@(posedge clk) disable iff (rst)
    cfg_addr == 7'h07 |-> (cfg_rdata & 8'hFD) == 8'h00); // R4

  AST_CACHE_EN_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    cfg_we && cfg_addr == 7'h50 |=> l2_en == $past(cfg_wdata[7])); // R6

  AST_SIZE_FORCED: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_we && cfg_addr == 7'h50) && cfg_addr == 7'h50 |-> cfg_rdata[2:0] == 3'b100); // R5

  AST_SMRAM_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(cfg_we && cfg_addr == 7'h60) |=> $stable(smram_ctl)); // R9

  AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    cfg_addr >= 7'h62 |-> cfg_rdata == 8'h00); // R10

endmodule

bind hb_cfg_space hb_cfg_space_chk u_chk (
  .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
  .cfg_we(cfg_we), .cfg_rdata(cfg_rdata), .l2_en(l2_en),
  .shadow_lo(shadow_lo), .smram_ctl(smram_ctl)
);

// File: tb/test_hb_cfg_space.sv
`timescale 1ns/1ps
module test_hb_cfg_space;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_rdata;
  logic       l2_en, l2_wback, l2_dual_bank;
  logic [7:0] shadow_lo, shadow_hi, smram_ctl;

  int checks = 0;
  int errors = 0;
  logic [7:0] mdl [128];

  always #10 clk = ~clk;

  hb_cfg_space i_hb_cfg_space (
    .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_we(cfg_we), .cfg_rdata(cfg_rdata), .l2_en(l2_en),
    .l2_wback(l2_wback), .l2_dual_bank(l2_dual_bank),
    .shadow_lo(shadow_lo), .shadow_hi(shadow_hi), .smram_ctl(smram_ctl)
  );

  function automatic bit plain_ofs(int a);
    return a == 'h04 || a == 'h05 || a == 'h0C || a == 'h0D || (a >= 'h51 && a <= 'h61);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 128; i++) mdl[i] = 8'h00;
    mdl['h00] = 8'h60; mdl['h01] = 8'h10; mdl['h02] = 8'h81; mdl['h03] = 8'h88;
    mdl['h08] = 8'h04; mdl['h0B] = 8'h06; mdl['h07] = 8'h02;
    mdl['h51] = 8'h01; mdl['h52] = 8'h01; mdl['h5A] = 8'h04; mdl['h5C] = 8'hC0;
    mdl['h5D] = 8'h20; mdl['h5F] = 8'hFF; mdl['h60] = 8'h20;
  endtask

  task automatic model_write(int a, logic [7:0] d);
    if (plain_ofs(a)) mdl[a] = d;
    else if (a == 'h07) mdl[a] = mdl[a] & ~(d & 8'hF9);
    else if (a == 'h50) mdl[a] = (d & 8'hF8) | 8'h04;
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h (addr %02h)", req, act, exp, cfg_addr);
    end
  endtask

  function automatic string req_of(int a);
    if (a <= 'h03 || (a >= 'h08 && a <= 'h0B)) return "R1";
    if (a == 'h07) return "R4";
    if (a == 'h50) return "R5";
    if (plain_ofs(a)) return "R2";
    if (a >= 'h62) return "R10";
    return "R3";
  endfunction

  task automatic read_chk(int a);
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = 7'(a);
    #1 check(req_of(a), cfg_rdata, mdl[a]);
  endtask

  task automatic outs_chk();
    check("R6", {7'b0, l2_en},        {7'b0, mdl['h50][7]});
    check("R6", {7'b0, l2_wback},     {7'b0, mdl['h50][6]});
    check("R6", {7'b0, l2_dual_bank}, {7'b0, mdl['h50][3]});
    check("R9", shadow_lo, mdl['h54]);
    check("R9", shadow_hi, mdl['h55]);
    check("R9", smram_ctl, mdl['h60]);
  endtask

  task automatic write_op(int a, logic [7:0] d);
    @(negedge clk);
    cfg_addr = 7'(a); cfg_wdata = d; cfg_we = 1'b1;
    #1 check("R8", cfg_rdata, mdl[a]);
    @(posedge clk);
    model_write(a, d);
    @(negedge clk);
    cfg_we = 1'b0;
    #1 check(req_of(a), cfg_rdata, mdl[a]);
    outs_chk();
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; cfg_we = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    model_reset();
  endtask

  initial begin
    #3_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'hC0FFEE));
    do_reset();
    // R7 reset defaults, all offsets
    for (int a = 0; a < 128; a++) begin
      @(negedge clk); cfg_addr = 7'(a);
      #1 check("R7", cfg_rdata, mdl[a]);
    end
    outs_chk();
    // directed corners
    write_op('h00, 8'h55);   // R1 id ignores writes
    write_op('h0B, 8'hFF);   // R1
    write_op('h07, 8'hFF);   // R4 bit1 outside mask survives
    write_op('h50, 8'h03);   // R5 size forced -> 04
    write_op('h50, 8'hFF);   // R5/R6 -> FC
    write_op('h50, 8'h48);   // R6 write-back + dual bank, cache off
    write_op('h06, 8'hAA);   // R3 unlisted
    write_op('h4F, 8'hAA);   // R3
    write_op('h62, 8'hAA);   // R10
    write_op('h7F, 8'h5A);   // R10
    write_op('h54, 8'hA5);   // R2/R8/R9
    write_op('h54, 8'h3C);   // R8 old value A5 seen during write
    write_op('h55, 8'h40);   // R9
    write_op('h60, 8'h31);   // R9
    write_op('h61, 8'hEE);   // R2 upper bound of plain set
    // constrained random
    for (int n = 0; n < 1500; n++) begin
      int a;
      logic [7:0] d;
      d = 8'($urandom);
      if ($urandom % 2) a = 'h50 + int'($urandom % 18);
      else a = int'($urandom % 128);
      if ($urandom % 4 != 0) write_op(a, d);
      else read_chk(a);
    end
    // reset again mid-run
    do_reset();
    for (int a = 'h50; a < 'h62; a++) read_chk(a);
    read_chk('h07);
    outs_chk();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule